// File: doc/BRIEF.md
# Paired-Access General Register File

This block holds the 32 general registers of a 32-bit processor, each 32 bits wide, and offers three views of the same storage. Two ordinary read ports and one write port move single 32-bit words. A double-word read port and a double-word write port treat two registers as one 64-bit operand, for double-precision values and 64-bit integers on a 32-bit machine. A special-register port reaches each general register through its address in the special-register space. All views alias one storage array.

A double-word index is six bits wide. The low five bits name the first register of the pair. The top bit picks the spacing of the second register: next-but-one when the bit is set, adjacent otherwise. The second index wraps around the file. When several write ports hit the same register in one cycle, a fixed priority decides the winner. A program-counter register sits beside the file. Each write to it moves the outgoing value into a previous-counter register.

Top module: `regfile_paired`

## Requirements
- R1: Reset clears all 32 registers, the program counter and the previous-counter register to zero.
- R2: A 32-bit write of `wr_data` to register `wr_idx` is visible on both read ports from the cycle after the clock edge. Reads are combinational, and in the cycle of a write they still return the old contents.
- R3: For a 6-bit pair index p, the first register is p[4:0]. The second register is (p[4:0] + 2) mod 32 when p[5] is 1, and (p[4:0] + 1) mod 32 when p[5] is 0. For example, 0x3F selects registers 31 and 1, and 0x1F selects 31 and 0.
- R4: The 64-bit pair read returns the first register in bits 63:32 and the second register in bits 31:0.
- R5: A 64-bit pair write stores bits 63:32 in the first register and bits 31:0 in the second register, both at the same clock edge. Other registers do not change.
- R6: A special-register address is the group number shifted left by 11, ORed with the index within the group. General register n sits in group 0 at index 0x400 + n, so its address is 0x0400 + n. Reads and writes at these addresses alias the same storage as the 32-bit ports.
- R7: A special-register address outside 0x0400..0x041F reads as zero, and a write to such an address changes no register.
- R8: When write ports target the same register in one cycle, the pair write wins over the 32-bit write, and the 32-bit write wins over the special-register write. Writes to different registers all take effect.
- R9: A program-counter write loads the new value and copies the old counter into the previous-counter register at the same edge. Without a write, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | 32-bit write enable |
| wr_idx | input | 5 | 32-bit write register index |
| wr_data | input | 32 | 32-bit write data |
| dw_rd_idx | input | 6 | Pair read index |
| dw_rd_data | output | 64 | Pair read data |
| dw_wr_en | input | 1 | Pair write enable |
| dw_wr_idx | input | 6 | Pair write index |
| dw_wr_data | input | 64 | Pair write data |
| spr_addr | input | 16 | Special-register address |
| spr_rdata | output | 32 | Special-register read data |
| spr_wr_en | input | 1 | Special-register write enable |
| spr_wdata | input | 32 | Special-register write data |
| pc_wr_en | input | 1 | Program-counter write enable |
| pc_wdata | input | 32 | New program-counter value |
| pc_q | output | 32 | Current program counter |
| ppc_q | output | 32 | Previous program counter |

## Verification
On every cycle, the assertions check the program-counter hand-over, the hold of both counter registers when no write is made, the landing of pair-write and 32-bit-write data, the priority of the pair write over a colliding 32-bit write, and that a write outside the special-register window leaves the array untouched. The bench alone shows the index arithmetic at every corner. It sweeps all 64 pair indices for both reads and writes, visits all 32 special-register aliases in both directions, and probes addresses just outside the window and in another group. It also checks old-data reads during a write and the three-way collision cases against a model that applies the priority rules.

// File: rtl/regfile_pair_pkg.sv
package regfile_pair_pkg;

    localparam int unsigned SPR_GROUP_SHIFT = 11;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_PAIR_UPPER,
        SRC_PAIR_LOWER,
        SRC_WORD,
        SRC_SPR
    } wr_src_e;

endpackage

// File: rtl/rf_pair_index.sv
module rf_pair_index #(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W:0]   pair_idx,
    output logic [IDX_W-1:0] first_idx,
    output logic [IDX_W-1:0] second_idx
);

    // The top index bit selects a stride of two; the sum wraps by truncation.
    always_comb begin
        first_idx  = pair_idx[IDX_W-1:0];
        second_idx = first_idx + (pair_idx[IDX_W] ? IDX_W'(2) : IDX_W'(1));
    end

endmodule

// File: rtl/rf_spr_window.sv
module rf_spr_window
    import regfile_pair_pkg::*;
#(
    parameter int unsigned SPR_AW     = 16,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned NREGS      = 32,
    parameter int unsigned GROUP      = 0,
    parameter int unsigned GPR_OFFSET = 'h400
) (
    input  logic [SPR_AW-1:0] spr_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  gpr_idx
);

    localparam logic [SPR_AW-1:0] BASE  = SPR_AW'((GROUP << SPR_GROUP_SHIFT) | GPR_OFFSET);
    localparam logic [SPR_AW:0]   LIMIT = {1'b0, BASE} + (SPR_AW + 1)'(NREGS);

    always_comb begin
        hit     = (spr_addr >= BASE) && ({1'b0, spr_addr} < LIMIT);
        gpr_idx = IDX_W'(spr_addr - BASE);
    end

endmodule

// File: rtl/rf_pc_unit.sv
module rf_pc_unit #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_wr_en,
    input  logic [DW-1:0] pc_wdata,
    output logic [DW-1:0] pc_q,
    output logic [DW-1:0] ppc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ppc_q <= '0;
        end else if (pc_wr_en) begin
            ppc_q <= pc_q;
            pc_q  <= pc_wdata;
        end
    end

    a_r9_ppc_takes_old_pc: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_en |=> (ppc_q == $past(pc_q)) && (pc_q == $past(pc_wdata)));

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_wr_en |=> $stable(pc_q) && $stable(ppc_q));

endmodule

// File: rtl/regfile_paired.sv
module regfile_paired
    import regfile_pair_pkg::*;
#(
    parameter int unsigned NREGS      = 32,
    parameter int unsigned DW         = 32,
    parameter int unsigned SPR_AW     = 16,
    parameter int unsigned SPR_GROUP  = 0,
    parameter int unsigned GPR_OFFSET = 'h400
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NREGS)-1:0]  rd_a_idx,
    output logic [DW-1:0]             rd_a_data,
    input  logic [$clog2(NREGS)-1:0]  rd_b_idx,
    output logic [DW-1:0]             rd_b_data,
    input  logic                      wr_en,
    input  logic [$clog2(NREGS)-1:0]  wr_idx,
    input  logic [DW-1:0]             wr_data,
    input  logic [$clog2(NREGS):0]    dw_rd_idx,
    output logic [2*DW-1:0]           dw_rd_data,
    input  logic                      dw_wr_en,
    input  logic [$clog2(NREGS):0]    dw_wr_idx,
    input  logic [2*DW-1:0]           dw_wr_data,
    input  logic [SPR_AW-1:0]         spr_addr,
    output logic [DW-1:0]             spr_rdata,
    input  logic                      spr_wr_en,
    input  logic [DW-1:0]             spr_wdata,
    input  logic                      pc_wr_en,
    input  logic [DW-1:0]             pc_wdata,
    output logic [DW-1:0]             pc_q,
    output logic [DW-1:0]             ppc_q
);

    localparam int unsigned IDX_W = $clog2(NREGS);

    logic [NREGS-1:0][DW-1:0] gpr_q;
    logic [IDX_W-1:0]         rdp_first, rdp_second;
    logic [IDX_W-1:0]         wrp_first, wrp_second;
    logic                     spr_hit;
    logic [IDX_W-1:0]         spr_idx;

    rf_pair_index #(.IDX_W(IDX_W)) u_rd_pair (
        .pair_idx   (dw_rd_idx),
        .first_idx  (rdp_first),
        .second_idx (rdp_second)
    );

    rf_pair_index #(.IDX_W(IDX_W)) u_wr_pair (
        .pair_idx   (dw_wr_idx),
        .first_idx  (wrp_first),
        .second_idx (wrp_second)
    );

    rf_spr_window #(
        .SPR_AW     (SPR_AW),
        .IDX_W      (IDX_W),
        .NREGS      (NREGS),
        .GROUP      (SPR_GROUP),
        .GPR_OFFSET (GPR_OFFSET)
    ) u_spr_win (
        .spr_addr (spr_addr),
        .hit      (spr_hit),
        .gpr_idx  (spr_idx)
    );

    rf_pc_unit #(.DW(DW)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_wr_en (pc_wr_en),
        .pc_wdata (pc_wdata),
        .pc_q     (pc_q),
        .ppc_q    (ppc_q)
    );

    // Per-register write source selection, highest priority first.
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        wr_src_e src;

        always_comb begin
            if (dw_wr_en && (wrp_first == IDX_W'(g))) begin
                src = SRC_PAIR_UPPER;
            end else if (dw_wr_en && (wrp_second == IDX_W'(g))) begin
                src = SRC_PAIR_LOWER;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                src = SRC_WORD;
            end else if (spr_wr_en && spr_hit && (spr_idx == IDX_W'(g))) begin
                src = SRC_SPR;
            end else begin
                src = SRC_HOLD;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gpr_q[g] <= '0;
            end else begin
                unique case (src)
                    SRC_PAIR_UPPER: gpr_q[g] <= dw_wr_data[2*DW-1:DW];
                    SRC_PAIR_LOWER: gpr_q[g] <= dw_wr_data[DW-1:0];
                    SRC_WORD:       gpr_q[g] <= wr_data;
                    SRC_SPR:        gpr_q[g] <= spr_wdata;
                    default:        gpr_q[g] <= gpr_q[g];
                endcase
            end
        end
    end

    always_comb begin
        rd_a_data  = gpr_q[rd_a_idx];
        rd_b_data  = gpr_q[rd_b_idx];
        dw_rd_data = {gpr_q[rdp_first], gpr_q[rdp_second]};
        spr_rdata  = spr_hit ? gpr_q[spr_idx] : '0;
    end

    a_r5_pair_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        dw_wr_en |=> {gpr_q[$past(wrp_first)], gpr_q[$past(wrp_second)]} == $past(dw_wr_data));

    a_r2_word_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(dw_wr_en && ((wrp_first == wr_idx) || (wrp_second == wr_idx))))
        |=> gpr_q[$past(wr_idx)] == $past(wr_data));

    a_r8_pair_beats_word: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_wr_en && wr_en && (wr_idx == wrp_first))
        |=> gpr_q[$past(wr_idx)] == $past(dw_wr_data[2*DW-1:DW]));

    a_r7_outside_window_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_wr_en && !spr_hit && !wr_en && !dw_wr_en) |=> gpr_q == $past(gpr_q));

endmodule

// File: tb/test_regfile_paired.sv
`timescale 1ns/1ps
module test_regfile_paired;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, dw_wr_en = 1'b0, spr_wr_en = 1'b0, pc_wr_en = 1'b0;
    logic [5:0]  dw_rd_idx = '0, dw_wr_idx = '0;
    logic [63:0] dw_rd_data, dw_wr_data = '0;
    logic [15:0] spr_addr = '0;
    logic [31:0] spr_rdata, spr_wdata = '0, pc_wdata = '0, pc_q, ppc_q;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [32];
    logic [31:0] m_pc = '0, m_ppc = '0;

    always #2.5 clk = ~clk;

    regfile_paired i_regfile_paired (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .dw_rd_idx(dw_rd_idx), .dw_rd_data(dw_rd_data),
        .dw_wr_en(dw_wr_en), .dw_wr_idx(dw_wr_idx), .dw_wr_data(dw_wr_data),
        .spr_addr(spr_addr), .spr_rdata(spr_rdata),
        .spr_wr_en(spr_wr_en), .spr_wdata(spr_wdata),
        .pc_wr_en(pc_wr_en), .pc_wdata(pc_wdata),
        .pc_q(pc_q), .ppc_q(ppc_q)
    );

    function automatic logic [4:0] second_of(input logic [5:0] p);
        return 5'((p[4:0] + (p[5] ? 2 : 1)) % 32);
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compares the whole file against the model through read port A; one check.
    task automatic check_file(input string req);
        int bad = -1;
        logic [31:0] got = '0;
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            #0.1;
            if (bad < 0 && rd_a_data !== model[i]) begin
                bad = i;
                got = rd_a_data;
            end
        end
        if (bad < 0) chk(req, "file", 64'd0, 64'd0);
        else chk(req, $sformatf("reg %0d", bad), {32'd0, got}, {32'd0, model[bad]});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0; dw_wr_en = 1'b0; spr_wr_en = 1'b0; pc_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        foreach (model[i]) model[i] = '0;
        m_pc = '0; m_ppc = '0;
    endtask

    // Drives all write ports at once; the model applies lowest priority first.
    task automatic combo(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                         input logic pe, input logic [5:0] pi, input logic [63:0] pd,
                         input logic se, input logic [15:0] sa, input logic [31:0] sd);
        wr_en = we; wr_idx = wi; wr_data = wd;
        dw_wr_en = pe; dw_wr_idx = pi; dw_wr_data = pd;
        spr_wr_en = se; spr_addr = sa; spr_wdata = sd;
        tick();
        if (se && sa >= 16'h0400 && sa < 16'h0420) model[sa - 16'h0400] = sd;
        if (we) model[wi] = wd;
        if (pe) begin
            model[pi[4:0]]     = pd[63:32];
            model[second_of(pi)] = pd[31:0];
        end
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check_file("R1");
        chk("R1", "pc", {32'd0, pc_q}, 64'd0);
        chk("R1", "ppc", {32'd0, ppc_q}, 64'd0);

        // R2: fill every register through the word port, read back on both ports
        for (int i = 0; i < 32; i++) begin
            combo(1'b1, 5'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(i << 3),
                  1'b0, '0, '0, 1'b0, '0, '0);
        end
        check_file("R2");
        for (int i = 0; i < 32; i++) begin
            rd_b_idx = 5'(31 - i);
            #0.1;
            chk("R2", "port b", {32'd0, rd_b_data}, {32'd0, model[31 - i]});
        end

        // R2: old contents during a same-cycle write
        rd_a_idx = 5'd3;
        wr_en = 1'b1; wr_idx = 5'd3; wr_data = 32'hDEAD_BEEF;
        #0.5;
        chk("R2", "read during write", {32'd0, rd_a_data}, {32'd0, model[3]});
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model[3] = 32'hDEAD_BEEF;
        chk("R2", "read after write", {32'd0, rd_a_data}, {32'd0, model[3]});

        // R3, R4: every pair read index
        for (int p = 0; p < 64; p++) begin
            dw_rd_idx = 6'(p);
            #0.1;
            chk("R3_R4", $sformatf("pair read %0h", p), dw_rd_data,
                {model[p % 32], model[second_of(6'(p))]});
        end

        // R5, R3: every pair write index, whole file compared after each
        for (int p = 0; p < 64; p++) begin
            combo(1'b0, '0, '0, 1'b1, 6'(p),
                  {32'h1100_0000 + 32'(p), 32'h2200_0000 + 32'(p * 7)}, 1'b0, '0, '0);
            check_file($sformatf("R5 pair write %0h", p));
        end

        // R6: alias reads through the special-register window
        for (int n = 0; n < 32; n++) begin
            spr_addr = 16'h0400 + 16'(n);
            #0.1;
            chk("R6", $sformatf("spr read %0d", n), {32'd0, spr_rdata}, {32'd0, model[n]});
        end
        // R6: alias writes through the window
        for (int n = 0; n < 32; n++) begin
            combo(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 16'h0400 + 16'(n), 32'h5A5A_0000 | 32'(n));
        end
        check_file("R6");

        // R7: addresses outside the window
        begin
            logic [15:0] outside [5] = '{16'h03FF, 16'h0420, 16'h0C00, 16'h0012, 16'hFFFF};
            foreach (outside[k]) begin
                spr_addr = outside[k];
                #0.1;
                chk("R7", $sformatf("read %h", outside[k]), {32'd0, spr_rdata}, 64'd0);
                combo(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, outside[k], 32'hBAD0_BAD0);
                check_file("R7");
            end
        end

        // R8: collisions
        combo(1'b1, 5'd6, 32'h0000_0606, 1'b1, 6'h05, 64'hAAAA_0005_BBBB_0006,
              1'b1, 16'h0405, 32'h0000_5555);
        check_file("R8 pair over word and spr");
        combo(1'b1, 5'd9, 32'h0909_0909, 1'b0, '0, '0, 1'b1, 16'h0409, 32'h5959_5959);
        check_file("R8 word over spr");
        combo(1'b1, 5'd12, 32'h0C0C_0C0C, 1'b1, 6'h2A, 64'hCCCC_000A_DDDD_000C,
              1'b1, 16'h040B, 32'h0B0B_0B0B);
        check_file("R8 stride pair with word and spr");
        combo(1'b1, 5'd1, 32'h0101_0101, 1'b1, 6'h3F, 64'hEEEE_001F_FFFF_0001,
              1'b1, 16'h041F, 32'h1F1F_1F1F);
        check_file("R8 wrapped pair");

        // R9: program counter hand-over
        for (int k = 1; k <= 4; k++) begin
            pc_wr_en = 1'b1;
            pc_wdata = 32'h0000_1000 * 32'(k) + 32'h4;
            tick();
            m_ppc = m_pc;
            m_pc = 32'h0000_1000 * 32'(k) + 32'h4;
            chk("R9", "pc", {32'd0, pc_q}, {32'd0, m_pc});
            chk("R9", "ppc", {32'd0, ppc_q}, {32'd0, m_ppc});
        end
        pc_wdata = 32'hFFFF_FFFF;
        tick();
        tick();
        chk("R9", "pc hold", {32'd0, pc_q}, {32'd0, m_pc});
        chk("R9", "ppc hold", {32'd0, ppc_q}, {32'd0, m_ppc});

        // R1: reset again after activity
        do_reset();
        check_file("R1 second reset");
        chk("R1", "pc after reset", {32'd0, pc_q}, 64'd0);
        chk("R1", "ppc after reset", {32'd0, ppc_q}, 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule